// File: doc/BRIEF.md
# Key-Locked DRAM Configuration Register Bank

This block is the software-visible configuration space of a DRAM controller. It holds a bank of 32-bit words reached through a word-addressed read/write port, and it does not model DRAM timing, the PHY or ECC. Word 0 is a protection word. The rest of the bank accepts writes only after a magic unlock key has been written to word 0. A second key freezes the whole bank until the next reset.

A few words are rewritten as they are stored. The configuration word (byte offset 0x04) keeps read-only fields fixed: a hardware version, an aperture code and a DRAM size code. The PHY status word (0x60) always shows the PHY idle and the PLL locked. The ECC test word (0x70) always shows a finished test that passed. Any other word is stored exactly as written.

Reads are registered, with one cycle of latency. A write that the bank refuses raises a one-cycle error pulse. A write is refused when it falls outside the bank or arrives while the bank is locked.

Top module: `cfgbank_top`

## Requirements
- R1: After reset the protection word reads 0x00 (soft-locked). The configuration word reads its fixed value {HW_VER in bits 31:28, 2'b11 in bits 3:2, SIZE_CODE in bits 1:0}, which is 0x3000000E at the defaults HW_VER=3 and SIZE_CODE=2. Every other word reads 0.
- R2: A write of 0xFC600309 to word 0 makes it read 0x01 (unlocked). Any other value except the hard key makes it read 0x00 (soft-locked). Such writes raise no error pulse.
- R3: A write of 0xDEADDEAD to word 0 makes it read 0x10 (hard-locked). From then until reset every write is discarded with an error pulse, including writes to word 0.
- R4: While soft-locked, a write to any in-range word other than word 0 is discarded and raises an error pulse.
- R5: While unlocked, a write to an ordinary word is stored unchanged, with no error pulse.
- R6: A write to the configuration word stores (data & ~0xF00FC04C) | fixed value. The mask clears bits 31:28, 19:14, 6 and 3:2. Data bits 1:0 are ORed with the size code.
- R7: A write to the PHY status word (offset 0x60) stores the data with bit 0 cleared and bit 4 set.
- R8: A write to the ECC test word (offset 0x70) stores the data with bit 12 set and bit 13 cleared.
- R9: The bank has NUM_WORDS words (default 64, minimum 29). A read of a word index at or above NUM_WORDS returns 0. A write there is discarded with an error pulse.
- R10: A read strobe in cycle t presents the data on rdata after that clock edge. rdata holds its value in cycles with no read strobe.
- R11: wrErr is high for exactly one cycle, the cycle after a refused write. It stays low after accepted writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Write strobe, one cycle per write |
| rdEn | input | 1 | Read strobe |
| wordAddr | input | 10 | Word index in the 4 KB window (byte offset / 4) |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| wrErr | output | 1 | One-cycle pulse for a refused write |

## Verification
A wrong lock state shows up at the ports within two cycles. The read of word 0 returns the wrong code, and the next write to an ordinary word either raises wrErr when it should not, or fails to raise it when it should. A bad write shaping or a dropped read-only mask appears in the very next read of the configuration, status or ECC word. The error pulse is checked on the cycle after each write. Read data is checked one cycle after each read strobe.

// File: rtl/cfgbank_pkg.sv
package cfgbank_pkg;

  typedef enum logic [7:0] {
    LOCK_SOFT = 8'h00,
    LOCK_OPEN = 8'h01,
    LOCK_HARD = 8'h10
  } lock_e;

  localparam logic [31:0] KEY_OPEN = 32'hFC60_0309;
  localparam logic [31:0] KEY_HARD = 32'hDEAD_DEAD;

  localparam int IDX_PROT = 0;
  localparam int IDX_CONF = 1;   // byte 0x04
  localparam int IDX_STAT = 24;  // byte 0x60
  localparam int IDX_ECC  = 28;  // byte 0x70

  localparam logic [31:0] CONF_RO_MASK = 32'hF00F_C04C;
  localparam int STAT_BUSY_BIT = 0;
  localparam int STAT_PLL_BIT  = 4;
  localparam int ECC_DONE_BIT  = 12;
  localparam int ECC_FAIL_BIT  = 13;

  typedef struct packed {
    logic       store;    // accepted write to a non-protection word
    logic       rd;       // read strobe
    logic       inRange;  // index lies inside the bank
    logic [9:0] idx;      // word index
  } stb_t;

endpackage

// File: rtl/cfgbank_ctrl.sv
module cfgbank_ctrl
  import cfgbank_pkg::*;
#(
  parameter int NUM_WORDS = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wrEn,
  input  logic        rdEn,
  input  logic [9:0]  wordAddr,
  input  logic [31:0] wdata,
  output stb_t        stb,
  output lock_e       lockState,
  output logic        wrErr
);

  localparam logic [10:0] LIMIT = 11'(NUM_WORDS);

  logic  inRange;
  logic  isProt;
  logic  acceptWr;
  logic  protWr;
  lock_e lockNext;

  assign inRange = {1'b0, wordAddr} < LIMIT;
  assign isProt  = (wordAddr == 10'(IDX_PROT));

  always_comb begin
    acceptWr = 1'b0;
    protWr   = 1'b0;
    if (wrEn && inRange && lockState != LOCK_HARD) begin
      if (isProt)                      protWr   = 1'b1;
      else if (lockState == LOCK_OPEN) acceptWr = 1'b1;
    end
  end

  always_comb begin
    lockNext = lockState;
    if (protWr) begin
      if (wdata == KEY_OPEN)      lockNext = LOCK_OPEN;
      else if (wdata == KEY_HARD) lockNext = LOCK_HARD;
      else                        lockNext = LOCK_SOFT;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lockState <= LOCK_SOFT;
      wrErr     <= 1'b0;
    end else begin
      lockState <= lockNext;
      wrErr     <= wrEn && !(acceptWr || protWr);
    end
  end

  assign stb.store   = acceptWr;
  assign stb.rd      = rdEn;
  assign stb.inRange = inRange;
  assign stb.idx     = wordAddr;

  assert_unlock_key_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wrEn && wordAddr == 10'd0 && wdata == KEY_OPEN && lockState != LOCK_HARD)
      |=> lockState == LOCK_OPEN);

  assert_hard_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    lockState == LOCK_HARD |=> lockState == LOCK_HARD);

  assert_soft_reject_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wrEn && lockState == LOCK_SOFT && wordAddr != 10'd0) |=> wrErr);

  assert_oor_reject_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wrEn && {1'b0, wordAddr} >= LIMIT) |=> wrErr);

  assert_err_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !wrEn |=> !wrErr);

endmodule

// File: rtl/cfgbank_dp.sv
module cfgbank_dp
  import cfgbank_pkg::*;
#(
  parameter int          NUM_WORDS = 64,
  parameter logic [3:0]  HW_VER    = 4'd3,
  parameter logic [1:0]  SIZE_CODE = 2'd2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  stb_t        stb,
  input  lock_e       lockState,
  input  logic [31:0] wdata,
  output logic [31:0] rdata
);

  localparam int          IDX_W      = $clog2(NUM_WORDS);
  localparam logic [31:0] CONF_FIXED = {HW_VER, 24'h0, 2'b11, SIZE_CODE};

  logic [31:0] words [1:NUM_WORDS-1];
  logic [31:0] shaped;
  logic [31:0] rdNext;

  always_comb begin
    shaped = wdata;
    if (stb.idx == 10'(IDX_CONF)) begin
      shaped = (wdata & ~CONF_RO_MASK) | CONF_FIXED;
    end else if (stb.idx == 10'(IDX_STAT)) begin
      shaped[STAT_BUSY_BIT] = 1'b0;
      shaped[STAT_PLL_BIT]  = 1'b1;
    end else if (stb.idx == 10'(IDX_ECC)) begin
      shaped[ECC_DONE_BIT] = 1'b1;
      shaped[ECC_FAIL_BIT] = 1'b0;
    end
  end

  for (genvar w = 1; w < NUM_WORDS; w++) begin : g_word
    localparam logic [31:0] RST_VAL = (w == IDX_CONF) ? CONF_FIXED : 32'h0;
    always_ff @(posedge clk) begin
      if (!rst_n)                                    words[w] <= RST_VAL;
      else if (stb.store && stb.idx == 10'(w))       words[w] <= shaped;
    end
  end

  always_comb begin
    if (!stb.inRange)                   rdNext = 32'h0;
    else if (stb.idx == 10'(IDX_PROT))  rdNext = {24'h0, lockState};
    else                                rdNext = words[stb.idx[IDX_W-1:0]];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      rdata <= 32'h0;
    else if (stb.rd) rdata <= rdNext;
  end

  assert_conf_fixed_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (words[IDX_CONF][31:28] == HW_VER) && (words[IDX_CONF][3:2] == 2'b11) &&
    (words[IDX_CONF][19:14] == 6'h0) && !words[IDX_CONF][6]);

  assert_stat_force_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (stb.store && stb.idx == 10'(IDX_STAT))
      |=> (!words[IDX_STAT][STAT_BUSY_BIT] && words[IDX_STAT][STAT_PLL_BIT]));

  assert_ecc_force_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (stb.store && stb.idx == 10'(IDX_ECC))
      |=> (words[IDX_ECC][ECC_DONE_BIT] && !words[IDX_ECC][ECC_FAIL_BIT]));

  assert_oor_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (stb.rd && !stb.inRange) |=> rdata == 32'h0);

  assert_rdata_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !stb.rd |=> $stable(rdata));

endmodule

// File: rtl/cfgbank_top.sv
module cfgbank_top
  import cfgbank_pkg::*;
#(
  parameter int          NUM_WORDS = 64,
  parameter logic [3:0]  HW_VER    = 4'd3,
  parameter logic [1:0]  SIZE_CODE = 2'd2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wrEn,
  input  logic        rdEn,
  input  logic [9:0]  wordAddr,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  output logic        wrErr
);

  stb_t  stb;
  lock_e lockState;

  cfgbank_ctrl #(.NUM_WORDS(NUM_WORDS)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .rdEn(rdEn),
    .wordAddr(wordAddr), .wdata(wdata),
    .stb(stb), .lockState(lockState), .wrErr(wrErr)
  );

  cfgbank_dp #(.NUM_WORDS(NUM_WORDS), .HW_VER(HW_VER), .SIZE_CODE(SIZE_CODE)) dp_i (
    .clk(clk), .rst_n(rst_n), .stb(stb), .lockState(lockState),
    .wdata(wdata), .rdata(rdata)
  );

endmodule

// File: tb/cfgbank_top_tb_top.sv
module cfgbank_top_tb_top;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wrEn = 1'b0;
  logic        rdEn = 1'b0;
  logic [9:0]  wordAddr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        wrErr;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [31:0] expQ[$];
  string       tagQ[$];
  logic        rdFired = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfgbank_top dut_i (
    .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .rdEn(rdEn),
    .wordAddr(wordAddr), .wdata(wdata), .rdata(rdata), .wrErr(wrErr)
  );

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  // Monitor: a read issued before a posedge is compared at the next negedge.
  always @(posedge clk) rdFired <= rdEn && rst_n;

  always @(negedge clk) begin
    if (rdFired) begin
      if (expQ.size() == 0) begin
        checks++; failures++;
        $display("FAIL R10 actual=unexpected-read expected=queued-item");
      end else begin
        check(rdata, expQ.pop_front(), tagQ.pop_front());
      end
    end
  end

  task automatic wr(input logic [11:0] off, input logic [31:0] d, input bit expErr, input string tag);
    @(negedge clk);
    wrEn = 1'b1; wordAddr = off[11:2]; wdata = d;
    @(negedge clk);
    wrEn = 1'b0;
    check({31'h0, wrErr}, {31'h0, expErr}, tag);
  endtask

  task automatic rd(input logic [11:0] off, input logic [31:0] exp, input string tag);
    @(negedge clk);
    rdEn = 1'b1; wordAddr = off[11:2];
    expQ.push_back(exp); tagQ.push_back(tag);
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  task automatic doReset();
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    doReset();
    // R1 reset state
    rd(12'h000, 32'h0000_0000, "R1 prot after reset");
    rd(12'h004, 32'h3000_000E, "R1 conf after reset");
    rd(12'h014, 32'h0000_0000, "R1 plain word after reset");
    // R4 soft-locked write discarded
    wr(12'h008, 32'h1111_2222, 1'b1, "R4 soft-locked write err");
    rd(12'h008, 32'h0000_0000, "R4 soft-locked word unchanged");
    // R2 protection word behaviour
    wr(12'h000, 32'h1234_5678, 1'b0, "R2 wrong key no err");
    rd(12'h000, 32'h0000_0000, "R2 wrong key soft");
    wr(12'h000, 32'hFC60_0309, 1'b0, "R2 unlock no err");
    rd(12'h000, 32'h0000_0001, "R2 unlocked code");
    // R5 plain store, R11 no pulse on accept
    wr(12'h008, 32'hA5A5_1234, 1'b0, "R11 accepted write no pulse");
    rd(12'h008, 32'hA5A5_1234, "R5 plain word");
    wr(12'h0FC, 32'h0BAD_F00D, 1'b0, "R5 last word accepted");
    rd(12'h0FC, 32'h0BAD_F00D, "R5 last word");
    // R6 configuration shaping
    wr(12'h004, 32'hFFFF_FFFF, 1'b0, "R6 conf write accepted");
    rd(12'h004, 32'h3FF0_3FBF, "R6 conf all ones");
    wr(12'h004, 32'h0000_0000, 1'b0, "R6 conf write accepted");
    rd(12'h004, 32'h3000_000E, "R6 conf zero");
    wr(12'h004, 32'h0000_0001, 1'b0, "R6 conf write accepted");
    rd(12'h004, 32'h3000_000F, "R6 conf size bit OR");
    // R7 PHY status
    wr(12'h060, 32'h0000_0001, 1'b0, "R7 status write accepted");
    rd(12'h060, 32'h0000_0010, "R7 status busy cleared");
    wr(12'h060, 32'hFFFF_FFEF, 1'b0, "R7 status write accepted");
    rd(12'h060, 32'hFFFF_FFFE, "R7 status pll forced");
    // R8 ECC test
    wr(12'h070, 32'h0000_2000, 1'b0, "R8 ecc write accepted");
    rd(12'h070, 32'h0000_1000, "R8 ecc done forced");
    wr(12'h070, 32'hFFFF_FFFF, 1'b0, "R8 ecc write accepted");
    rd(12'h070, 32'hFFFF_DFFF, "R8 ecc fail cleared");
    // R9 out of range
    wr(12'h100, 32'hDEAD_BEEF, 1'b1, "R9 oor write err");
    rd(12'h100, 32'h0000_0000, "R9 oor read zero");
    rd(12'hFFC, 32'h0000_0000, "R9 top of window read zero");
    rd(12'h008, 32'hA5A5_1234, "R9 oor write did not alias");
    // R10 hold without read strobe
    rd(12'h0FC, 32'h0BAD_F00D, "R10 read latency");
    repeat (2) @(negedge clk);
    check(rdata, 32'h0BAD_F00D, "R10 rdata holds");
    // R11 pulse lasts one cycle
    wr(12'h200, 32'h0, 1'b1, "R11 refused write pulse");
    @(negedge clk);
    check({31'h0, wrErr}, 32'h0, "R11 pulse one cycle");
    // R4 relock then rejected
    wr(12'h000, 32'h0000_0000, 1'b0, "R2 relock no err");
    rd(12'h000, 32'h0000_0000, "R2 relocked");
    wr(12'h008, 32'h7777_7777, 1'b1, "R4 relocked write err");
    wr(12'h000, 32'hFC60_0309, 1'b0, "R2 reunlock");
    rd(12'h008, 32'hA5A5_1234, "R4 relocked word unchanged");
    // R3 hard lock
    wr(12'h000, 32'hDEAD_DEAD, 1'b0, "R3 hard key accepted");
    rd(12'h000, 32'h0000_0010, "R3 hard code");
    wr(12'h000, 32'hFC60_0309, 1'b1, "R3 unlock refused");
    rd(12'h000, 32'h0000_0010, "R3 still hard");
    wr(12'h008, 32'h5555_5555, 1'b1, "R3 data write refused");
    rd(12'h008, 32'hA5A5_1234, "R3 word unchanged");
    doReset();
    rd(12'h000, 32'h0000_0000, "R3 reset clears hard lock");
    rd(12'h008, 32'h0000_0000, "R1 word cleared by reset");
    rd(12'h004, 32'h3000_000E, "R1 conf reloaded");
    repeat (2) @(negedge clk);
    if (expQ.size() != 0) begin
      checks++; failures++;
      $display("FAIL R10 actual=%0d expected=0 pending reads", expQ.size());
    end
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule